// File: doc/BRIEF.md
# Video Memory Write Queue Drain

This block holds CPU data-port writes in a short queue and retires them into three video memories: a byte-wide pattern memory (VRAM), a word-wide colour memory (CRAM) and a word-wide vertical-scroll memory (VSRAM). The display timing grants an external access slot with a one-cycle strobe. Each slot retires at most one memory write. A CPU read that is waiting takes precedence, and the slot is then handed back to the read path unused.

Each queued entry holds a 6-bit access code, an address, a 16-bit value and a timestamp. An entry becomes eligible once its timestamp is not later than the current cycle. A VRAM entry is split across two slots. Word writes to CRAM and VSRAM finish in one slot. The block keeps the value of the most recently completed write so that the read path can fill in the undefined bits of colour and scroll reads.

Top module: `vram_fifo_drain`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `full_o`=0), no write strobe or `unused_slot_o` is active, and `last_val_o` is 0.
- R2: The queue holds DEPTH entries (4 by default) and retires them in push order. `full_o` is 1 while DEPTH entries are held. A push while `full_o` is 1 is dropped.
- R3: A slot writes only when the queue is non-empty and the head timestamp is less than or equal to `cycle_i`. Otherwise no strobe fires and the head stays in place.
- R4: `read_req_i` marks a read as waiting. The next slot, or a slot in the same cycle, writes nothing and pulses `unused_slot_o`. This clears the waiting mark, so the following slot serves the queue again.
- R5: Code low nibble 4'h1 is a VRAM write. Its first slot writes the value bits [15:8] to the entry address and keeps the entry at the head.
- R6: The second slot of a VRAM entry writes the value bits [7:0] to the address XOR 1, removes the entry, and sets `last_val_o` to the full 16-bit value.
- R7: Code low nibble 4'h3 is a CRAM write. It writes the whole value at word index (address>>1) mod CRAM_WORDS, removes the entry, and sets `last_val_o`.
- R8: Code low nibble 4'h5 is a VSRAM write to word index (address>>1)&63. When that index is below VSRAM_WORDS, it writes the value and sets `last_val_o`. When the index is at or above VSRAM_WORDS, no strobe fires, the entry is removed and `last_val_o` is unchanged.
- R9: Only the low 4 bits of the code select the access type; bits [5:4] are ignored. Any other low nibble removes the entry with no strobe and leaves `last_val_o` unchanged.
- R10: Write strobes and `unused_slot_o` are registered. They are high for exactly the one cycle after the slot edge, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | TW | Current timing cycle count |
| push_i | input | 1 | Queue a write entry |
| push_code_i | input | 6 | Access code of the entry |
| push_addr_i | input | AW | Byte address of the entry |
| push_data_i | input | 16 | Value of the entry |
| push_stamp_i | input | TW | Earliest cycle the entry may be written |
| full_o | output | 1 | Queue full, pushes dropped |
| empty_o | output | 1 | Queue empty |
| slot_i | input | 1 | External access slot strobe |
| read_req_i | input | 1 | A CPU read is waiting for a slot |
| unused_slot_o | output | 1 | Slot given up to a waiting read |
| vram_we_o | output | 1 | VRAM byte write strobe |
| vram_addr_o | output | AW | VRAM byte address |
| vram_wdata_o | output | 8 | VRAM byte value |
| cram_we_o | output | 1 | CRAM word write strobe |
| cram_addr_o | output | $clog2(CRAM_WORDS) | CRAM word index |
| cram_wdata_o | output | 16 | CRAM word value |
| vsram_we_o | output | 1 | VSRAM word write strobe |
| vsram_addr_o | output | $clog2(VSRAM_WORDS) | VSRAM word index |
| vsram_wdata_o | output | 16 | VSRAM word value |
| last_val_o | output | 16 | Value of the last completed write |

## Verification
The bench builds the block with its default parameters: a queue depth of 4, 16-bit addresses and timestamps, 64 CRAM words and 40 VSRAM words. With a depth of 4, the full flag and a dropped fifth push can be reached after a handful of pushes. With 40 VSRAM words, both sides of the range check can be reached from ordinary addresses: index 39 is written, while indices 40 and 63 are discarded. The 16-bit timestamps allow a held entry to be released by moving `cycle_i` past its stamp.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int CODE_W = 6;
  localparam int DATA_W = 16;

  localparam logic [3:0] ACC_VRAM_WR  = 4'h1;
  localparam logic [3:0] ACC_CRAM_WR  = 4'h3;
  localparam logic [3:0] ACC_VSRAM_WR = 4'h5;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_READ_GAP,
    ACT_VRAM_HI,
    ACT_VRAM_LO,
    ACT_CRAM,
    ACT_VSRAM,
    ACT_DROP
  } act_e;
endpackage

// File: rtl/wq_shift.sv
module wq_shift
  import vfd_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int TW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [CODE_W-1:0] push_code_i,
  input  logic [AW-1:0]     push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [TW-1:0]     push_stamp_i,
  input  logic              pop_i,
  input  logic              mark_i,
  output logic              head_valid_o,
  output logic [CODE_W-1:0] head_code_o,
  output logic [AW-1:0]     head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic [TW-1:0]     head_stamp_o,
  output logic              head_partial_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int ENT_W = CODE_W + AW + DATA_W + TW;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] ent_q   [DEPTH];
  logic [ENT_W-1:0] nxt_ent [DEPTH];
  logic             part_q  [DEPTH];
  logic             nxt_part[DEPTH];
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] wr_idx;
  logic             push_ok;
  logic [ENT_W-1:0] new_ent;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i && !full_o;
  assign wr_idx  = pop_i ? count_q - 1'b1 : count_q;
  assign new_ent = {push_code_i, push_addr_i, push_data_i, push_stamp_i};

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < DEPTH - 1) begin : g_mid
      assign nxt_ent[i]  = ent_q[i+1];
      assign nxt_part[i] = part_q[i+1];
    end else begin : g_top
      assign nxt_ent[i]  = '0;
      assign nxt_part[i] = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i]  <= '0;
        part_q[i] <= 1'b0;
      end else if (push_ok && wr_idx == CNT_W'(i)) begin
        ent_q[i]  <= new_ent;
        part_q[i] <= 1'b0;
      end else if (pop_i) begin
        ent_q[i]  <= nxt_ent[i];
        part_q[i] <= nxt_part[i];
      end else if (mark_i && i == 0) begin
        part_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      case ({push_ok, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_valid_o   = !empty_o;
  assign {head_code_o, head_addr_o, head_data_o, head_stamp_o} = ent_q[0];
  assign head_partial_o = part_q[0];

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o && $stable(head_addr_o));

  // R2
  pop_needs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  // R5
  partial_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i |=> head_partial_o && !empty_o && $stable(head_data_o));
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import vfd_pkg::*;
#(
  parameter int AW          = 16,
  parameter int TW          = 16,
  parameter int VSRAM_WORDS = 40
) (
  input  logic              slot_i,
  input  logic              read_pend_i,
  input  logic              head_valid_i,
  input  logic [CODE_W-1:0] head_code_i,
  input  logic [AW-1:0]     head_addr_i,
  input  logic [TW-1:0]     head_stamp_i,
  input  logic              head_partial_i,
  input  logic [TW-1:0]     cycle_i,
  output act_e              act_o,
  output logic              pop_o,
  output logic              mark_o,
  output logic              take_read_o
);
  logic       eligible;
  logic [5:0] vs_idx;
  logic       unused_bits;

  assign eligible    = head_valid_i && (head_stamp_i <= cycle_i);
  assign vs_idx      = head_addr_i[6:1];
  assign unused_bits = ^{head_code_i[CODE_W-1:4], head_addr_i[AW-1:7], head_addr_i[0]};

  always_comb begin
    act_o       = ACT_IDLE;
    pop_o       = 1'b0;
    mark_o      = 1'b0;
    take_read_o = 1'b0;
    if (slot_i) begin
      if (read_pend_i) begin
        act_o       = ACT_READ_GAP;
        take_read_o = 1'b1;
      end else if (eligible) begin
        case (head_code_i[3:0])
          ACC_VRAM_WR: begin
            if (head_partial_i) begin
              act_o = ACT_VRAM_LO;
              pop_o = 1'b1;
            end else begin
              act_o  = ACT_VRAM_HI;
              mark_o = 1'b1;
            end
          end
          ACC_CRAM_WR: begin
            act_o = ACT_CRAM;
            pop_o = 1'b1;
          end
          ACC_VSRAM_WR: begin
            act_o = (int'(vs_idx) < VSRAM_WORDS) ? ACT_VSRAM : ACT_DROP;
            pop_o = 1'b1;
          end
          default: begin
            act_o = ACT_DROP;
            pop_o = 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mem_wr_port.sv
module mem_wr_port
  import vfd_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CRAM_WORDS  = 64,
  parameter int VSRAM_WORDS = 40
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  act_e                           act_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic                           unused_slot_o,
  output logic                           vram_we_o,
  output logic [AW-1:0]                  vram_addr_o,
  output logic [7:0]                     vram_wdata_o,
  output logic                           cram_we_o,
  output logic [$clog2(CRAM_WORDS)-1:0]  cram_addr_o,
  output logic [DATA_W-1:0]              cram_wdata_o,
  output logic                           vsram_we_o,
  output logic [$clog2(VSRAM_WORDS)-1:0] vsram_addr_o,
  output logic [DATA_W-1:0]              vsram_wdata_o,
  output logic [DATA_W-1:0]              last_val_o
);
  localparam int CRAM_AW = $clog2(CRAM_WORDS);
  localparam int VS_AW   = $clog2(VSRAM_WORDS);

  logic [5:0] vs_idx;
  assign vs_idx = addr_i[6:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unused_slot_o <= 1'b0;
      vram_we_o     <= 1'b0;
      vram_addr_o   <= '0;
      vram_wdata_o  <= '0;
      cram_we_o     <= 1'b0;
      cram_addr_o   <= '0;
      cram_wdata_o  <= '0;
      vsram_we_o    <= 1'b0;
      vsram_addr_o  <= '0;
      vsram_wdata_o <= '0;
      last_val_o    <= '0;
    end else begin
      unused_slot_o <= (act_i == ACT_READ_GAP);
      vram_we_o     <= (act_i == ACT_VRAM_HI) || (act_i == ACT_VRAM_LO);
      cram_we_o     <= (act_i == ACT_CRAM);
      vsram_we_o    <= (act_i == ACT_VSRAM);
      case (act_i)
        ACT_VRAM_HI: begin
          vram_addr_o  <= addr_i;
          vram_wdata_o <= data_i[15:8];
        end
        ACT_VRAM_LO: begin
          vram_addr_o  <= addr_i ^ AW'(1);
          vram_wdata_o <= data_i[7:0];
          last_val_o   <= data_i;
        end
        ACT_CRAM: begin
          cram_addr_o  <= addr_i[CRAM_AW:1];
          cram_wdata_o <= data_i;
          last_val_o   <= data_i;
        end
        ACT_VSRAM: begin
          vsram_addr_o  <= vs_idx[VS_AW-1:0];
          vsram_wdata_o <= data_i;
          last_val_o    <= data_i;
        end
        default: ;
      endcase
    end
  end

  // R8
  vsram_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsram_we_o |-> (int'(vsram_addr_o) < VSRAM_WORDS));

  // R6
  last_val_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last_val_o) |-> (vram_we_o || cram_we_o || vsram_we_o));
endmodule

// File: rtl/vram_fifo_drain.sv
module vram_fifo_drain
  import vfd_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int AW          = 16,
  parameter int TW          = 16,
  parameter int CRAM_WORDS  = 64,
  parameter int VSRAM_WORDS = 40
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [TW-1:0]                  cycle_i,
  input  logic                           push_i,
  input  logic [5:0]                     push_code_i,
  input  logic [AW-1:0]                  push_addr_i,
  input  logic [15:0]                    push_data_i,
  input  logic [TW-1:0]                  push_stamp_i,
  output logic                           full_o,
  output logic                           empty_o,
  input  logic                           slot_i,
  input  logic                           read_req_i,
  output logic                           unused_slot_o,
  output logic                           vram_we_o,
  output logic [AW-1:0]                  vram_addr_o,
  output logic [7:0]                     vram_wdata_o,
  output logic                           cram_we_o,
  output logic [$clog2(CRAM_WORDS)-1:0]  cram_addr_o,
  output logic [15:0]                    cram_wdata_o,
  output logic                           vsram_we_o,
  output logic [$clog2(VSRAM_WORDS)-1:0] vsram_addr_o,
  output logic [15:0]                    vsram_wdata_o,
  output logic [15:0]                    last_val_o
);
  logic              head_valid, head_partial;
  logic [CODE_W-1:0] head_code;
  logic [AW-1:0]     head_addr;
  logic [DATA_W-1:0] head_data;
  logic [TW-1:0]     head_stamp;
  logic              pop, mark, take_read;
  logic              pend_q, pend_eff;
  act_e              act;

  assign pend_eff = pend_q | read_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_eff & ~take_read;
  end

  wq_shift #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_queue (
    .clk_i, .rst_ni,
    .push_i, .push_code_i, .push_addr_i, .push_data_i, .push_stamp_i,
    .pop_i(pop), .mark_i(mark),
    .head_valid_o(head_valid), .head_code_o(head_code), .head_addr_o(head_addr),
    .head_data_o(head_data), .head_stamp_o(head_stamp), .head_partial_o(head_partial),
    .full_o, .empty_o
  );

  slot_ctrl #(.AW(AW), .TW(TW), .VSRAM_WORDS(VSRAM_WORDS)) u_ctrl (
    .slot_i, .read_pend_i(pend_eff),
    .head_valid_i(head_valid), .head_code_i(head_code), .head_addr_i(head_addr),
    .head_stamp_i(head_stamp), .head_partial_i(head_partial), .cycle_i,
    .act_o(act), .pop_o(pop), .mark_o(mark), .take_read_o(take_read)
  );

  mem_wr_port #(.AW(AW), .CRAM_WORDS(CRAM_WORDS), .VSRAM_WORDS(VSRAM_WORDS)) u_wr (
    .clk_i, .rst_ni, .act_i(act), .addr_i(head_addr), .data_i(head_data),
    .unused_slot_o, .vram_we_o, .vram_addr_o, .vram_wdata_o,
    .cram_we_o, .cram_addr_o, .cram_wdata_o,
    .vsram_we_o, .vsram_addr_o, .vsram_wdata_o, .last_val_o
  );

  // R10
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vram_we_o, cram_we_o, vsram_we_o, unused_slot_o}));

  // R10
  strobe_needs_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_we_o || cram_we_o || vsram_we_o || unused_slot_o) |-> $past(slot_i));

  // R4
  read_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && (pend_q || read_req_i)) |=> unused_slot_o && !vram_we_o && !cram_we_o && !vsram_we_o);

  // R3
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && empty_o && !pend_q && !read_req_i) |=> !(vram_we_o || cram_we_o || vsram_we_o || unused_slot_o));
endmodule

// File: tb/sim_vram_fifo_drain.sv
module sim_vram_fifo_drain;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cycle_i = '0;
  logic        push_i = 1'b0;
  logic [5:0]  push_code_i = '0;
  logic [15:0] push_addr_i = '0;
  logic [15:0] push_data_i = '0;
  logic [15:0] push_stamp_i = '0;
  logic        slot_i = 1'b0;
  logic        read_req_i = 1'b0;
  logic        full_o, empty_o, unused_slot_o;
  logic        vram_we_o, cram_we_o, vsram_we_o;
  logic [15:0] vram_addr_o;
  logic [7:0]  vram_wdata_o;
  logic [5:0]  cram_addr_o, vsram_addr_o;
  logic [15:0] cram_wdata_o, vsram_wdata_o, last_val_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vram_fifo_drain u0 (.*);

  // {code, addr, data}
  localparam logic [37:0] VEC [8] = '{
    {6'h01, 16'h1234, 16'hABCD},
    {6'h03, 16'h0046, 16'h0EEE},
    {6'h05, 16'h004E, 16'h03FF},
    {6'h05, 16'h0050, 16'h1111},
    {6'h01, 16'h0001, 16'h5A3C},
    {6'h33, 16'h00FE, 16'h0123},
    {6'h02, 16'h0010, 16'h9999},
    {6'h05, 16'h0000, 16'h0777}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [5:0] c, input logic [15:0] a, input logic [15:0] d,
                      input logic [15:0] s);
    @(negedge clk_i);
    push_i = 1'b1; push_code_i = c; push_addr_i = a; push_data_i = d; push_stamp_i = s;
    @(negedge clk_i);
    push_i = 1'b0;
  endtask

  // returns at the negedge after the slot edge, where registered strobes are visible
  task automatic slot();
    @(negedge clk_i);
    slot_i = 1'b1;
    @(negedge clk_i);
    slot_i = 1'b0;
  endtask

  function automatic logic [3:0] strobes();
    return {vram_we_o, cram_we_o, vsram_we_o, unused_slot_o};
  endfunction

  initial begin
    logic [15:0] exp_last;
    #(CLK_PERIOD * 3);
    // R1 reset state
    check("R1 empty", empty_o, 1);
    check("R1 full", full_o, 0);
    check("R1 strobes", strobes(), 0);
    check("R1 last", last_val_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_last = 16'h0;

    // table walk: one entry at a time
    for (int k = 0; k < 8; k++) begin
      logic [5:0]  c;
      logic [15:0] a, d;
      logic [5:0]  vi;
      {c, a, d} = VEC[k];
      vi = a[6:1];
      push(c, a, d, 16'h0);
      slot();
      case (c[3:0])
        4'h1: begin
          check("R5 hi strobe", strobes(), 4'b1000);
          check("R5 hi addr", vram_addr_o, a);
          check("R5 hi data", vram_wdata_o, d[15:8]);
          check("R5 entry stays", empty_o, 0);
          check("R5 last unchanged", last_val_o, exp_last);
          slot();
          check("R6 lo strobe", strobes(), 4'b1000);
          check("R6 lo addr", vram_addr_o, a ^ 16'h1);
          check("R6 lo data", vram_wdata_o, d[7:0]);
          exp_last = d;
          check("R6 last", last_val_o, exp_last);
        end
        4'h3: begin
          check("R7 R9 cram strobe", strobes(), 4'b0100);
          check("R7 cram addr", cram_addr_o, a[6:1]);
          check("R7 cram data", cram_wdata_o, d);
          exp_last = d;
          check("R7 last", last_val_o, exp_last);
        end
        4'h5: begin
          if (vi < 40) begin
            check("R8 vsram strobe", strobes(), 4'b0010);
            check("R8 vsram addr", vsram_addr_o, vi);
            check("R8 vsram data", vsram_wdata_o, d);
            exp_last = d;
          end else begin
            check("R8 discard no strobe", strobes(), 0);
          end
          check("R8 last", last_val_o, exp_last);
        end
        default: begin
          check("R9 drop no strobe", strobes(), 0);
          check("R9 last unchanged", last_val_o, exp_last);
        end
      endcase
      check("R2 entry removed", empty_o, 1);
    end

    // R3 timestamp holds entry
    cycle_i = 16'd50;
    push(6'h03, 16'h0002, 16'h0ABC, 16'd100);
    slot();
    check("R3 early no strobe", strobes(), 0);
    check("R3 early stays", empty_o, 0);
    cycle_i = 16'd100;
    slot();
    check("R3 due cram", strobes(), 4'b0100);
    check("R3 due data", cram_wdata_o, 16'h0ABC);
    cycle_i = 16'd0;

    // R3 slot on empty queue
    slot();
    check("R3 empty slot", strobes(), 0);

    // R4 waiting read takes slot first
    push(6'h01, 16'h2000, 16'hBEEF, 16'h0);
    @(negedge clk_i); read_req_i = 1'b1;
    @(negedge clk_i); read_req_i = 1'b0;
    slot();
    check("R4 gap strobe", strobes(), 4'b0001);
    slot();
    check("R4 queue resumes", strobes(), 4'b1000);
    check("R4 hi data", vram_wdata_o, 8'hBE);
    // R4 read request in the same cycle as the slot
    @(negedge clk_i); read_req_i = 1'b1; slot_i = 1'b1;
    @(negedge clk_i); read_req_i = 1'b0; slot_i = 1'b0;
    check("R4 same-cycle gap", strobes(), 4'b0001);
    slot();
    check("R4 lo after gap", vram_wdata_o, 8'hEF);
    check("R4 lo addr", vram_addr_o, 16'h2001);

    // R2 fill, overflow drop, order
    for (int k = 0; k < 4; k++) push(6'h03, 16'(2 * k), 16'h0100 + 16'(k), 16'h0);
    check("R2 full", full_o, 1);
    push(6'h03, 16'h0020, 16'h0999, 16'h0);
    for (int k = 0; k < 4; k++) begin
      slot();
      check("R2 order data", cram_wdata_o, 16'h0100 + 16'(k));
      check("R2 order addr", cram_addr_o, 6'(k));
    end
    check("R2 drained", empty_o, 1);
    slot();
    check("R2 overflow dropped", strobes(), 0);
    // R10 strobe lasts one cycle
    push(6'h05, 16'h0004, 16'h0042, 16'h0);
    slot();
    check("R10 strobe on", vsram_we_o, 1);
    @(negedge clk_i);
    check("R10 strobe off", vsram_we_o, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule